// File: doc/BRIEF.md
# Mobile SDRAM Low-Power Mode Manager

This block sits on the controller side of a mobile SDRAM and owns the clock-enable pin. It moves the memory between normal operation and three low-power states: power-down, self refresh and deep power-down. While it does so it drives the command pins. The command sequencer keeps ownership of ordinary traffic and reports whether every bank is precharged. The manager raises `ready` only when the memory can take normal commands again.

A sleep request carries a mode code. Power-down is entered at once, and the manager records whether any row was left open, which makes it an active power-down rather than a precharge power-down. Self refresh first writes a partial-array refresh field into the extended mode register and then issues the refresh command with the clock enable low. Deep power-down uses the burst-terminate encoding with the clock enable low.

Every exit holds `ready` low and drives NOPs until a timing counter expires. Deep power-down loses the memory contents, so its exit replays the full initialization sequence. That sequence is a precharge of all banks, two refreshes, a mode register write and an extended mode register write, and it reuses the last partial-array setting.

Top module: `lp_mode_mgr`

## Requirements
- R1: After reset `ready` is 1, `cke` is 1 and the command pins {csN,rasN,casN,weN} carry NOP (0111). Other encodings used: mode write 0000, refresh 0001, precharge 0010 (addr bit 10 high = all banks), burst terminate 0110.
- R2: With `ready` high, `sleepReq` with `sleepMode`=00 drives `cke` to 0 with NOP on the next cycle and drops `ready`. `activePd` shows 1 if `allBanksIdle` was 0 when the request was taken, and 0 otherwise.
- R3: A `wakeReq` in power-down drives `cke` to 1 on the next cycle. NOPs are then held for EXIT_PD cycles with `ready` low, and `ready` rises after that.
- R4: `sleepMode`=01 with all banks idle first issues an extended mode write: mode-write encoding, `ba`=10, addr[2:0] set to the partial-array code and the other address bits 0, `cke` 1. This is followed by MRD_CYC NOP cycles, then one refresh-encoding cycle with `cke` 0, then NOP with `cke` 0.
- R5: Partial-array codes 000 (all four banks), 001 (two banks), 010 (one bank), 101 (half bank) and 110 (quarter bank) are written unchanged. The reserved codes 011, 100 and 111 are written as 000.
- R6: A `wakeReq` in self refresh drives `cke` to 1 on the next cycle. NOPs are then held for EXIT_SR cycles with `ready` low, and `ready` rises after that.
- R7: `sleepMode`=10 with all banks idle issues one cycle of burst-terminate encoding with `cke` 0, then NOP with `cke` 0.
- R8: A self-refresh or deep power-down request while `allBanksIdle` is 0 is ignored. So is a request with `sleepMode`=11. In each case `ready` and `cke` stay 1 and NOP is driven.
- R9: A `wakeReq` in deep power-down raises `cke`. NOPs are then held for INIT_CYC cycles. After that the manager issues precharge-all, refresh, refresh, a mode write (`ba`=00, addr=MODE_VAL) and an extended mode write carrying the stored partial-array code. Each of these is followed by GAP_CYC NOP cycles, and then `ready` rises.
- R10: `sleepReq` while `ready` is low and `wakeReq` while `ready` is high have no effect on the pins or on exit timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | Request to enter the low-power state named by sleepMode |
| sleepMode | input | 2 | 00 power-down, 01 self refresh, 10 deep power-down |
| pasrCode | input | 3 | Partial-array self-refresh code captured on self-refresh entry |
| wakeReq | input | 1 | Request to leave the current low-power state |
| allBanksIdle | input | 1 | All banks precharged, from the command sequencer |
| cke | output | 1 | Clock enable to the memory |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address for mode writes |
| addr | output | ADDR_W | Address / op-code bus |
| ready | output | 1 | Memory available for normal commands |
| activePd | output | 1 | Last power-down entered with a row open |

## Verification
The bench builds the block with EXIT_PD=2, EXIT_SR=3, MRD_CYC=2, INIT_CYC=4 and GAP_CYC=2. With these short windows every exit path and the whole re-initialization sequence run in a few dozen cycles, so the bench checks each cycle of every wait window, not just its end. That small setting allows all eight partial-array codes to be swept through a full self-refresh entry and exit. Power-down is run with banks both busy and idle, and the refused entries are covered under each blocking condition.

// File: rtl/lp_mode_pkg.sv
package lp_mode_pkg;
  typedef enum logic [2:0] {
    CMD_NOP, CMD_MRS, CMD_EMRS, CMD_REF, CMD_PRE, CMD_BST
  } cmd_e;

  typedef enum logic [2:0] {
    SEL_PD, SEL_SR, SEL_MRD, SEL_INIT, SEL_GAP
  } cntSel_e;

  typedef struct packed {
    cmd_e    cmd;
    logic    ckeLow;
    logic    capPasr;
    logic    loadCnt;
    cntSel_e cntSel;
    logic    cntDec;
  } strobe_t;

  localparam logic [1:0] MODE_PD  = 2'b00;
  localparam logic [1:0] MODE_SR  = 2'b01;
  localparam logic [1:0] MODE_DPD = 2'b10;
endpackage

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lp_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic [1:0] sleepMode,
  input  logic       wakeReq,
  input  logic       allBanksIdle,
  input  logic       cntZero,
  output strobe_t    strobes,
  output logic       ready,
  output logic       activePd
);
  localparam int STEPS = 5;

  typedef enum logic [3:0] {
    ST_READY, ST_PD, ST_SR_EMR, ST_SR_GAP, ST_SR_IN, ST_SR_SLEEP,
    ST_DPD_IN, ST_DPD_SLEEP, ST_EXIT, ST_DPD_WAKE, ST_INIT_CMD, ST_INIT_GAP
  } state_e;

  state_e stateQ, stateD;
  logic [2:0] stepQ, stepD;
  logic activePdQ, activePdD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_READY;
      stepQ     <= '0;
      activePdQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      stepQ     <= stepD;
      activePdQ <= activePdD;
    end
  end

  always_comb begin
    stateD    = stateQ;
    stepD     = stepQ;
    activePdD = activePdQ;
    strobes   = '{cmd: CMD_NOP, ckeLow: 1'b0, capPasr: 1'b0, loadCnt: 1'b0,
                  cntSel: SEL_PD, cntDec: 1'b0};
    case (stateQ)
      ST_READY: if (sleepReq) begin
        if (sleepMode == MODE_PD) begin
          stateD    = ST_PD;
          activePdD = !allBanksIdle;
        end else if (sleepMode == MODE_SR && allBanksIdle) begin
          stateD          = ST_SR_EMR;
          strobes.capPasr = 1'b1;
        end else if (sleepMode == MODE_DPD && allBanksIdle) begin
          stateD = ST_DPD_IN;
        end
      end
      ST_PD: begin
        strobes.ckeLow = 1'b1;
        if (wakeReq) begin
          stateD          = ST_EXIT;
          strobes.loadCnt = 1'b1;
          strobes.cntSel  = SEL_PD;
        end
      end
      ST_SR_EMR: begin
        strobes.cmd     = CMD_EMRS;
        strobes.loadCnt = 1'b1;
        strobes.cntSel  = SEL_MRD;
        stateD          = ST_SR_GAP;
      end
      ST_SR_GAP: if (cntZero) stateD = ST_SR_IN; else strobes.cntDec = 1'b1;
      ST_SR_IN: begin
        strobes.ckeLow = 1'b1;
        strobes.cmd    = CMD_REF;
        stateD         = ST_SR_SLEEP;
      end
      ST_SR_SLEEP: begin
        strobes.ckeLow = 1'b1;
        if (wakeReq) begin
          stateD          = ST_EXIT;
          strobes.loadCnt = 1'b1;
          strobes.cntSel  = SEL_SR;
        end
      end
      ST_DPD_IN: begin
        strobes.ckeLow = 1'b1;
        strobes.cmd    = CMD_BST;
        stateD         = ST_DPD_SLEEP;
      end
      ST_DPD_SLEEP: begin
        strobes.ckeLow = 1'b1;
        if (wakeReq) begin
          stateD          = ST_DPD_WAKE;
          strobes.loadCnt = 1'b1;
          strobes.cntSel  = SEL_INIT;
        end
      end
      ST_EXIT: if (cntZero) stateD = ST_READY; else strobes.cntDec = 1'b1;
      ST_DPD_WAKE: if (cntZero) begin
        stateD = ST_INIT_CMD;
        stepD  = '0;
      end else strobes.cntDec = 1'b1;
      ST_INIT_CMD: begin
        case (stepQ)
          3'd0:         strobes.cmd = CMD_PRE;
          3'd1, 3'd2:   strobes.cmd = CMD_REF;
          3'd3:         strobes.cmd = CMD_MRS;
          default:      strobes.cmd = CMD_EMRS;
        endcase
        strobes.loadCnt = 1'b1;
        strobes.cntSel  = SEL_GAP;
        stateD          = ST_INIT_GAP;
      end
      ST_INIT_GAP: if (cntZero) begin
        if (stepQ == 3'(STEPS - 1)) stateD = ST_READY;
        else begin
          stateD = ST_INIT_CMD;
          stepD  = stepQ + 3'd1;
        end
      end else strobes.cntDec = 1'b1;
      default: stateD = ST_READY;
    endcase
  end

  assign ready    = (stateQ == ST_READY);
  assign activePd = activePdQ;

  // R8: refused entries leave the manager ready
  assert_busy_refused_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_READY && sleepReq && sleepMode != MODE_PD && !allBanksIdle) |=> ready);

  // R3: a wake in power-down always starts the exit wait
  assert_pd_wake_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PD && wakeReq) |=> (stateQ == ST_EXIT));

  // R9: the final init gap leads straight to ready
  assert_init_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_INIT_GAP && cntZero && stepQ == 3'(STEPS - 1)) |=> ready);
endmodule

// File: rtl/lp_mode_dp.sv
module lp_mode_dp
  import lp_mode_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int CNT_W    = 16,
  parameter int EXIT_PD  = 2,
  parameter int EXIT_SR  = 16,
  parameter int MRD_CYC  = 2,
  parameter int INIT_CYC = 26700,
  parameter int GAP_CYC  = 10,
  parameter logic [ADDR_W-1:0] MODE_VAL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [2:0]        pasrCode,
  output logic              cntZero,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr
);
  localparam int PRE_BIT = 10;

  logic [CNT_W-1:0] cntQ;
  logic [2:0] pasrQ;
  logic [2:0] pasrLegal;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    case (pasrCode)
      3'b000, 3'b001, 3'b010, 3'b101, 3'b110: pasrLegal = pasrCode;
      default:                                pasrLegal = 3'b000;
    endcase
  end

  always_comb begin
    case (strobes.cntSel)
      SEL_PD:   loadVal = CNT_W'(EXIT_PD - 1);
      SEL_SR:   loadVal = CNT_W'(EXIT_SR - 1);
      SEL_MRD:  loadVal = CNT_W'(MRD_CYC - 1);
      SEL_INIT: loadVal = CNT_W'(INIT_CYC - 1);
      default:  loadVal = CNT_W'(GAP_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      pasrQ <= 3'b000;
    end else begin
      if (strobes.loadCnt)     cntQ <= loadVal;
      else if (strobes.cntDec) cntQ <= cntQ - 1'b1;
      if (strobes.capPasr)     pasrQ <= pasrLegal;
    end
  end

  assign cntZero = (cntQ == '0);

  always_comb begin
    {csN, rasN, casN, weN} = 4'b0111;
    ba   = 2'b00;
    addr = '0;
    case (strobes.cmd)
      CMD_MRS:  begin {csN, rasN, casN, weN} = 4'b0000; addr = MODE_VAL; end
      CMD_EMRS: begin {csN, rasN, casN, weN} = 4'b0000; ba = 2'b10; addr[2:0] = pasrQ; end
      CMD_REF:  {csN, rasN, casN, weN} = 4'b0001;
      CMD_PRE:  begin {csN, rasN, casN, weN} = 4'b0010; addr[PRE_BIT] = 1'b1; end
      CMD_BST:  {csN, rasN, casN, weN} = 4'b0110;
      default:  ;
    endcase
  end

  assign cke = !strobes.ckeLow;

  // R6: exit windows never count below zero
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntDec |-> !cntZero);

  // R5: the stored partial-array code is always a legal one
  assert_pasr_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pasrQ != 3'b011 && pasrQ != 3'b100 && pasrQ != 3'b111));
endmodule

// File: rtl/lp_mode_mgr.sv
module lp_mode_mgr
  import lp_mode_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int CNT_W    = 16,
  parameter int EXIT_PD  = 2,
  parameter int EXIT_SR  = 16,
  parameter int MRD_CYC  = 2,
  parameter int INIT_CYC = 26700,
  parameter int GAP_CYC  = 10,
  parameter logic [ADDR_W-1:0] MODE_VAL = 13'h0032
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepReq,
  input  logic [1:0]        sleepMode,
  input  logic [2:0]        pasrCode,
  input  logic              wakeReq,
  input  logic              allBanksIdle,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready,
  output logic              activePd
);
  strobe_t strobes;
  logic cntZero;

  lp_mode_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .sleepMode(sleepMode),
    .wakeReq(wakeReq), .allBanksIdle(allBanksIdle), .cntZero(cntZero),
    .strobes(strobes), .ready(ready), .activePd(activePd)
  );

  lp_mode_dp #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .EXIT_PD(EXIT_PD), .EXIT_SR(EXIT_SR),
    .MRD_CYC(MRD_CYC), .INIT_CYC(INIT_CYC), .GAP_CYC(GAP_CYC), .MODE_VAL(MODE_VAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pasrCode(pasrCode),
    .cntZero(cntZero), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr)
  );

  // R1: ready is never shown with the clock enable low
  assert_ready_cke_R1: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> cke);

  // R7: burst terminate with cke low only follows all banks idle
  assert_dpd_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    ({csN, rasN, casN, weN} == 4'b0110 && !cke) |-> $past(allBanksIdle));
endmodule

// File: tb/sim_lp_mode_mgr.sv
module sim_lp_mode_mgr;
  localparam int ADDR_W = 13;
  localparam int EXIT_PD = 2, EXIT_SR = 3, MRD_CYC = 2, INIT_CYC = 4, GAP_CYC = 2;
  localparam logic [ADDR_W-1:0] MODE_VAL = 13'h0032;
  localparam logic [3:0] NOPC = 4'b0111, MRSC = 4'b0000, REFC = 4'b0001,
                         PREC = 4'b0010, BSTC = 4'b0110;

  logic clk = 0, rstN = 0, sleepReq = 0, wakeReq = 0, allBanksIdle = 1;
  logic [1:0] sleepMode = 0;
  logic [2:0] pasrCode = 0;
  logic cke, csN, rasN, casN, weN, ready, activePd;
  logic [1:0] ba;
  logic [ADDR_W-1:0] addr;
  int nChk = 0, nFail = 0;

  always #10 clk = ~clk;

  lp_mode_mgr #(.ADDR_W(ADDR_W), .CNT_W(8), .EXIT_PD(EXIT_PD), .EXIT_SR(EXIT_SR),
    .MRD_CYC(MRD_CYC), .INIT_CYC(INIT_CYC), .GAP_CYC(GAP_CYC), .MODE_VAL(MODE_VAL)) u0 (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .sleepMode(sleepMode),
    .pasrCode(pasrCode), .wakeReq(wakeReq), .allBanksIdle(allBanksIdle),
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .ba(ba),
    .addr(addr), .ready(ready), .activePd(activePd));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkPins(string tag, logic expCke, logic [3:0] expCmd, logic expReady);
    chk({tag, " cke"}, 32'(cke), 32'(expCke));
    chk({tag, " cmd"}, 32'({csN, rasN, casN, weN}), 32'(expCmd));
    chk({tag, " ready"}, 32'(ready), 32'(expReady));
  endtask

  function automatic logic [2:0] legalPasr(logic [2:0] c);
    return (c == 3'b011 || c == 3'b100 || c == 3'b111) ? 3'b000 : c;
  endfunction

  task automatic exitWait(string tag, int cycles);
    wakeReq = 1; sleepReq = 1; sleepMode = 2'b00;   // R10: sleep held during exit
    step();
    wakeReq = 0;
    chkPins(tag, 1'b1, NOPC, 1'b0);
    for (int k = 1; k < cycles; k++) begin
      step();
      chkPins(tag, 1'b1, NOPC, 1'b0);
    end
    step();
    sleepReq = 0;
    chkPins({tag, " R10 done"}, 1'b1, NOPC, 1'b1);
  endtask

  task automatic srCycle(logic [2:0] c);
    allBanksIdle = 1; sleepReq = 1; sleepMode = 2'b01; pasrCode = c;
    step();
    sleepReq = 0;
    chkPins("R4 emr", 1'b1, MRSC, 1'b0);
    chk("R4 ba", 32'(ba), 32'd2);
    chk("R5 addr", 32'(addr), 32'(legalPasr(c)));
    for (int k = 0; k < MRD_CYC; k++) begin
      step();
      chkPins("R4 mrd gap", 1'b1, NOPC, 1'b0);
    end
    step();
    chkPins("R4 ref", 1'b0, REFC, 1'b0);
    step();
    chkPins("R4 asleep", 1'b0, NOPC, 1'b0);
    exitWait("R6 exit", EXIT_SR);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    step(); step();
    rstN = 1;
    step();
    chkPins("R1 reset", 1'b1, NOPC, 1'b1);

    for (int busy = 1; busy >= 0; busy--) begin
      allBanksIdle = (busy == 0); sleepReq = 1; sleepMode = 2'b00;
      step();
      sleepReq = 0;
      chkPins("R2 pd", 1'b0, NOPC, 1'b0);
      chk("R2 activePd", 32'(activePd), 32'(busy));
      step(); step();
      chkPins("R2 pd hold", 1'b0, NOPC, 1'b0);
      exitWait("R3 exit", EXIT_PD);
    end

    wakeReq = 1;
    step();
    wakeReq = 0;
    chkPins("R10 wake when ready", 1'b1, NOPC, 1'b1);

    for (int c = 0; c < 8; c++) srCycle(3'(c));
    srCycle(3'b101);

    allBanksIdle = 0;
    for (int m = 1; m <= 2; m++) begin
      sleepReq = 1; sleepMode = 2'(m);
      step();
      sleepReq = 0;
      chkPins("R8 busy refused", 1'b1, NOPC, 1'b1);
    end
    allBanksIdle = 1; sleepReq = 1; sleepMode = 2'b11;
    step();
    sleepReq = 0;
    chkPins("R8 mode 11 refused", 1'b1, NOPC, 1'b1);

    sleepReq = 1; sleepMode = 2'b10;
    step();
    sleepReq = 0;
    chkPins("R7 bst", 1'b0, BSTC, 1'b0);
    step();
    chkPins("R7 asleep", 1'b0, NOPC, 1'b0);
    wakeReq = 1;
    step();
    wakeReq = 0;
    chkPins("R9 init wait", 1'b1, NOPC, 1'b0);
    for (int k = 1; k < INIT_CYC; k++) begin
      step();
      chkPins("R9 init wait", 1'b1, NOPC, 1'b0);
    end
    for (int i = 0; i < 5; i++) begin
      step();
      case (i)
        0: begin chkPins("R9 pre", 1'b1, PREC, 1'b0); chk("R9 a10", 32'(addr[10]), 32'd1); end
        1, 2: chkPins("R9 ref", 1'b1, REFC, 1'b0);
        3: begin chkPins("R9 mrs", 1'b1, MRSC, 1'b0); chk("R9 mrs addr", 32'(addr), 32'(MODE_VAL));
                 chk("R9 mrs ba", 32'(ba), 32'd0); end
        default: begin chkPins("R9 emrs", 1'b1, MRSC, 1'b0); chk("R9 emrs ba", 32'(ba), 32'd2);
                 chk("R9 emrs addr", 32'(addr), 32'd5); end
      endcase
      for (int g = 0; g < GAP_CYC; g++) begin
        step();
        chkPins("R9 gap", 1'b1, NOPC, 1'b0);
      end
    end
    step();
    chkPins("R9 ready", 1'b1, NOPC, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule